// File: doc/BRIEF.md
# Computer-Operating-Properly Watchdog with Bus-Mapped Restart

This block watches for a stalled processor. It counts the cycles of a prescaled oscillator clock, which arrives as a one-cycle enable pulse on `tick`. If software does not restart it before the selected period runs out, the block raises a single-clock reset request. Two configuration inputs control it. One picks between a short period and a long period. The other turns the block off. A monitor-mode qualifier input also turns it off.

Software restarts the period with a bus write of any value to the top address, 0xFFFF. That address is also where the processor fetches the low byte of its reset vector. A read there therefore returns the vector byte from an input port and leaves the count alone. The block has no interrupt output. Expiry only produces the reset request. Storage of the configuration bits and the sequencing of the system reset are done outside the block.

Top module: `cop_watchdog`

## Requirements
- R1: Synchronous active-high `rst` drives `reset_req` low and zeroes the count. After `rst` falls, a full period passes before the next request.
- R2: With `rate_short` = 0, `reset_req` rises on the clock edge that samples the LONG_TICKS-th `tick` since the count was last zeroed. The reset default of the rate bit is 0, so this long period is the default.
- R3: With `rate_short` = 1, `reset_req` rises on the edge that samples the SHORT_TICKS-th `tick` since the count was last zeroed.
- R4: The count advances only on cycles where `tick` is 1. Cycles with `tick` = 0 neither advance the count nor raise a request.
- R5: A cycle with `bus_wr` = 1 and `bus_addr` = 0xFFFF zeroes the count, whatever the value on `bus_wdata`, and starts a full new period. A write to any other address has no effect.
- R6: An expiry holds `reset_req` high for exactly one clock and zeroes the count, so the next request comes one full period later.
- R7: While `bus_rd` = 1 and `bus_addr` = 0xFFFF, `bus_rdata` equals `vector_lo`. Otherwise `bus_rdata` is 0. A read never changes the count.
- R8: While `cop_off` = 1, the count is held at zero and no request is made. After `cop_off` returns to 0, a full period passes before a request.
- R9: While `monitor_hv` = 1, the block behaves exactly as it does with `cop_off` = 1.
- R10: A change of `rate_short` does not clear the count. If the count has already reached the new limit, the next `tick` raises the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable from the oscillator prescaler |
| rate_short | input | 1 | 1 selects the short period, 0 selects the long period |
| cop_off | input | 1 | 1 turns the watchdog off |
| monitor_hv | input | 1 | Monitor-mode qualifier (high-voltage entry); 1 forces the block off |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | DATA_W | Bus write data (ignored) |
| vector_lo | input | DATA_W | Low byte of the reset vector |
| bus_rdata | output | DATA_W | Bus read data |
| reset_req | output | 1 | One-clock reset request on expiry |

## Verification
The bench builds the block with SHORT_TICKS = 12 and LONG_TICKS = 40 instead of 8176 and 262,128. Every expiry therefore takes a few dozen cycles, so both periods, back-to-back expiries and reloads can each be exercised many times. These short limits also make it cheap to switch the rate in the middle of a count, both past the short limit and below it. They also allow a disabled stretch far longer than either period, which shows that nothing counts while the block is off.

// File: rtl/cop_pkg.sv
package cop_pkg;

    typedef enum logic {
        MODE_OFF = 1'b0,
        MODE_RUN = 1'b1
    } cop_mode_e;

    typedef struct packed {
        logic clear;   // restart write seen at the watchdog address
        logic rd_hit;  // read of the watchdog address
    } bus_evt_t;

    function automatic int unsigned period_ticks(
        input logic        short_sel,
        input int unsigned short_n,
        input int unsigned long_n
    );
        return short_sel ? short_n : long_n;
    endfunction

endpackage

// File: rtl/cop_decode.sv
module cop_decode
    import cop_pkg::*;
#(
    parameter int unsigned     ADDR_W     = 16,
    parameter int unsigned     DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CLEAR_ADDR = '1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] vector_i,
    output bus_evt_t          evt_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic hit;

    always_comb begin
        hit          = (addr_i == CLEAR_ADDR);
        evt_o.clear  = wr_i & hit;
        evt_o.rd_hit = rd_i & hit;
        rdata_o      = evt_o.rd_hit ? vector_i : '0;
    end

endmodule

// File: rtl/cop_counter.sv
module cop_counter
    import cop_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 8176,
    parameter int unsigned LONG_TICKS  = 262128
) (
    input  logic      clk,
    input  logic      rst,
    input  cop_mode_e mode_i,
    input  bus_evt_t  evt_i,
    input  logic      tick_i,
    input  logic      rate_short_i,
    output logic      reset_req_o
);

    localparam int unsigned CW = $clog2(LONG_TICKS);
    localparam logic [CW-1:0] LONG_M1 = CW'(LONG_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_m1;
    logic          at_limit;

    always_comb begin
        lim_m1   = CW'(period_ticks(rate_short_i, SHORT_TICKS, LONG_TICKS) - 1);
        at_limit = (cnt_q >= lim_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            reset_req_o <= 1'b0;
        end else begin
            reset_req_o <= 1'b0;
            if (mode_i == MODE_OFF || evt_i.clear) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                if (at_limit) begin
                    cnt_q       <= '0;
                    reset_req_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    initial begin
        if (SHORT_TICKS < 2 || SHORT_TICKS > LONG_TICKS)
            $error("cop_counter: SHORT_TICKS must be in 2..LONG_TICKS");
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reset_req_o |=> !reset_req_o);                                      // R6

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LONG_M1);                                                  // R2

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_OFF) |=> (!reset_req_o && cnt_q == '0));            // R8

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        evt_i.clear |=> (!reset_req_o && cnt_q == '0));                     // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_RUN && !evt_i.clear && !tick_i)
            |=> ($stable(cnt_q) && !reset_req_o));                           // R4

    AST_READ_INERT: assert property (@(posedge clk) disable iff (rst)
        (evt_i.rd_hit && !evt_i.clear && !tick_i && mode_i == MODE_RUN)
            |=> $stable(cnt_q));                                             // R7

endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
    import cop_pkg::*;
#(
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SHORT_TICKS = 8176,
    parameter int unsigned LONG_TICKS  = 262128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rate_short,
    input  logic              cop_off,
    input  logic              monitor_hv,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] vector_lo,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_req
);

    localparam logic [ADDR_W-1:0] CLEAR_ADDR = '1;

    bus_evt_t  evt;
    cop_mode_e mode;
    logic      wdata_unused;

    always_comb begin
        mode         = (cop_off || monitor_hv) ? MODE_OFF : MODE_RUN;
        wdata_unused = ^bus_wdata;  // data value never matters for a restart
    end

    cop_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .CLEAR_ADDR (CLEAR_ADDR)
    ) u_decode (
        .addr_i   (bus_addr),
        .wr_i     (bus_wr),
        .rd_i     (bus_rd),
        .vector_i (vector_lo),
        .evt_o    (evt),
        .rdata_o  (bus_rdata)
    );

    cop_counter #(
        .SHORT_TICKS (SHORT_TICKS),
        .LONG_TICKS  (LONG_TICKS)
    ) u_counter (
        .clk          (clk),
        .rst          (rst),
        .mode_i       (mode),
        .evt_i        (evt),
        .tick_i       (tick),
        .rate_short_i (rate_short),
        .reset_req_o  (reset_req)
    );

    AST_MON_OFF: assert property (@(posedge clk) disable iff (rst)
        monitor_hv |=> !reset_req);                                         // R9

    AST_RD_PASS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == CLEAR_ADDR) |-> (bus_rdata == vector_lo));   // R7

    AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));                                     // R7

endmodule

// File: tb/tb_cop_watchdog.sv
`timescale 1ns/1ps
module tb_cop_watchdog;

    localparam int SHORT_N = 12;
    localparam int LONG_N  = 40;
    localparam logic [7:0] VEC = 8'hC3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        rate_short = 1'b0;
    logic        cop_off = 1'b0;
    logic        monitor_hv = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  vector_lo = VEC;
    logic [7:0]  bus_rdata;
    logic        reset_req;

    always #4 clk = ~clk;  // 125 MHz

    cop_watchdog #(
        .ADDR_W      (16),
        .DATA_W      (8),
        .SHORT_TICKS (SHORT_N),
        .LONG_TICKS  (LONG_N)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .rate_short (rate_short),
        .cop_off    (cop_off),
        .monitor_hv (monitor_hv),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .vector_lo  (vector_lo),
        .bus_rdata  (bus_rdata),
        .reset_req  (reset_req)
    );

    int    checks = 0;
    int    fails  = 0;
    bit    exp_q[$];
    string tag_q[$];

    // settings applied by the driver at each negative edge
    bit w_rst = 1'b1, w_rate = 1'b0, w_off = 1'b0, w_mon = 1'b0;

    // scoreboard monitor: one expected reset_req value per driven cycle
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (reset_req !== e) begin
                fails++;
                $display("FAIL %s: reset_req actual=%0b expected=%0b at %0t", t, reset_req, e, $time);
            end
        end
    end

    task automatic cyc(input bit t, input bit w, input bit r, input logic [15:0] a,
                       input logic [7:0] d, input bit e, input string tag);
        @(negedge clk);
        rst = w_rst; rate_short = w_rate; cop_off = w_off; monitor_hv = w_mon;
        tick = t; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic run(input int n, input bit pulse_last, input string tag);
        for (int i = 0; i < n; i++)
            cyc(1'b1, 1'b0, 1'b0, 16'h0000, 8'h00, pulse_last && (i == n - 1), tag);
    endtask

    task automatic check_rdata(input logic [7:0] e, input string tag);
        #1;
        checks++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s: bus_rdata actual=%0h expected=%0h", tag, bus_rdata, e);
        end
    endtask

    task automatic run_all();
        // R1: reset state
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 16'h0, 8'h0, 1'b0, "R1");
        check_rdata(8'h00, "R7");
        w_rst = 1'b0;

        // R2: long default period
        run(LONG_N, 1'b1, "R2");
        // R6: single-cycle pulse, then full reload
        cyc(1'b0, 1'b0, 1'b0, 16'h0, 8'h0, 1'b0, "R6");
        run(LONG_N, 1'b1, "R6");

        // R4: idle cycles between ticks do not count
        w_rate = 1'b1;
        for (int i = 0; i < SHORT_N; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 16'h0, 8'h0, i == SHORT_N - 1, "R4");
            cyc(1'b0, 1'b0, 1'b0, 16'h0, 8'h0, 1'b0, "R4");
        end
        // R3: short period
        run(SHORT_N, 1'b1, "R3");

        // R5: any-data write to 0xFFFF restarts
        run(10, 1'b0, "R5");
        cyc(1'b0, 1'b1, 1'b0, 16'hFFFF, 8'h5A, 1'b0, "R5");
        run(SHORT_N, 1'b1, "R5");
        run(4, 1'b0, "R5");
        cyc(1'b0, 1'b1, 1'b0, 16'hFFFF, 8'h00, 1'b0, "R5");
        run(SHORT_N, 1'b1, "R5");
        // R5: write elsewhere is ignored
        run(5, 1'b0, "R5");
        cyc(1'b0, 1'b1, 1'b0, 16'hFFFE, 8'hFF, 1'b0, "R5");
        run(SHORT_N - 5, 1'b1, "R5");

        // R7: read returns vector, leaves count alone
        run(5, 1'b0, "R7");
        cyc(1'b0, 1'b0, 1'b1, 16'hFFFF, 8'h00, 1'b0, "R7");
        check_rdata(VEC, "R7");
        run(SHORT_N - 5, 1'b1, "R7");

        // R8: disable bit
        run(6, 1'b0, "R8");
        w_off = 1'b1;
        run(100, 1'b0, "R8");
        w_off = 1'b0;
        run(SHORT_N, 1'b1, "R8");

        // R9: monitor qualifier
        run(7, 1'b0, "R9");
        w_mon = 1'b1;
        run(100, 1'b0, "R9");
        w_mon = 1'b0;
        run(SHORT_N, 1'b1, "R9");

        // R10: rate change past the short limit fires on next tick
        w_rate = 1'b0;
        run(30, 1'b0, "R10");
        w_rate = 1'b1;
        run(1, 1'b1, "R10");
        // R10: rate change below the limit keeps the count
        w_rate = 1'b0;
        run(5, 1'b0, "R10");
        w_rate = 1'b1;
        run(SHORT_N - 5, 1'b1, "R10");

        // R1: reset in mid count restarts the period
        run(8, 1'b0, "R1");
        w_rst = 1'b1;
        cyc(1'b1, 1'b0, 1'b0, 16'h0, 8'h0, 1'b0, "R1");
        w_rst = 1'b0;
        run(SHORT_N, 1'b1, "R1");

        // drain
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 16'h0, 8'h0, 1'b0, "R6");
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                #(8 * 100000);
                fails++;
                $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule